// File: doc/BRIEF.md
# Ring FIFO Watermark and Breakpoint Interrupt Controller

This block watches the state of a ring command FIFO every clock cycle and condenses it into a small status word and one interrupt line. It takes the following inputs:

- the current fill distance;
- the read and write pointers;
- a breakpoint address;
- a high and a low watermark.

From these it derives five flags:

- overflow, when the fill is above the high watermark;
- underflow, when the fill is below the low watermark;
- breakpoint, when the reader has reached the breakpoint address;
- command-idle;
- read-idle.

A 6-bit control word, written over a simple 16-bit register bus, does three things. It enables each interrupt cause separately. It arms the breakpoint comparator. It carries a global read enable that gates the interrupt as a whole.

The status word is read-only at its own bus offset. The control word can be written and read back at a second offset. The block also drives the read-enable and link-enable control bits out to neighbouring logic. Pointer arithmetic and command execution belong to other blocks.

Flags and interrupt are registered. Each reflects the inputs sampled at the previous rising clock edge.

Top module: `wmbp_irq_ctrl`

## Requirements
- R1: Status bit 0 (overflow) is 1 exactly when the distance sampled at the previous edge was strictly greater than the high watermark; equality gives 0.
- R2: Status bit 1 (underflow) is 1 exactly when the sampled distance was strictly less than the low watermark; equality gives 0.
- R3: Status bit 4 (breakpoint) is 1 when control bit 1 (breakpoint arm) was set and the read pointer equalled the breakpoint address. With control bit 1 clear, status bit 4 stays 0 even when the pointers match.
- R4: Status bit 3 (command-idle) is 1 exactly when the sampled distance was zero.
- R5: Status bit 2 (read-idle) is 1 when the sampled distance was zero, or the read pointer equalled the write pointer, or the read pointer equalled the breakpoint address (regardless of arming).
- R6: The irq output is the OR of three terms, ANDed with control bit 0 (read enable). The terms are: breakpoint flag AND control bit 5; overflow flag AND control bit 2; underflow flag AND control bit 3.
- R7: irq is registered. It follows a change of the FIFO inputs one edge later. After a control write it follows two edges later, because the write itself takes one edge.
- R8: During reset and until the first update, the status word reads 0x000C (both idle bits set, the rest clear). The control word reads 0x0000 and irq is 0.
- R9: The status word sits at bus offset 0x0 and the control word at 0x2. Writes to offset 0x0 or to any other offset leave the control word unchanged. A control write keeps only bits 5:0, and bits 15:6 read as 0. Unmapped offsets read 0. Outputs rd_en and link_en carry control bits 0 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| distance | input | AW | Current FIFO fill distance |
| rd_ptr | input | AW | FIFO read pointer |
| wr_ptr | input | AW | FIFO write pointer |
| bp_addr | input | AW | Breakpoint address |
| hi_mark | input | AW | High watermark |
| lo_mark | input | AW | Low watermark |
| reg_addr | input | REG_AW | Register bus offset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| rd_en | output | 1 | Control read-enable bit |
| link_en | output | 1 | Control link-enable bit |
| irq | output | 1 | Combined FIFO interrupt |

## Verification
The assertions assume that the FIFO inputs are stable around each rising clock edge and carry no X once reset has been released. They also assume that the register bus presents at most one write per cycle, with a defined address whenever the strobe is high.

The bench drives every input at the falling edge and holds it across the next rising edge. It keeps the strobe low except in single-cycle write tasks. It places the watermarks far apart, so each flag is provoked on its own, with distances at, just above and just below each threshold.

// File: rtl/wmbp_pkg.sv
package wmbp_pkg;

  localparam int REG_W  = 16;
  localparam int CTRL_W = 6;
  localparam int STAT_W = 5;

  // control word, bit 5 down to bit 0
  typedef struct packed {
    logic bp_ie;     // bit 5
    logic link;      // bit 4
    logic unf_ie;    // bit 3
    logic ovf_ie;    // bit 2
    logic bp_arm;    // bit 1
    logic rd_en;     // bit 0
  } ctrl_t;

  // status word, bit 4 down to bit 0
  typedef struct packed {
    logic bp;        // bit 4
    logic cmd_idle;  // bit 3
    logic rd_idle;   // bit 2
    logic unf;       // bit 1
    logic ovf;       // bit 0
  } stat_t;

  localparam stat_t STAT_RESET = '{bp: 1'b0, cmd_idle: 1'b1, rd_idle: 1'b1,
                                   unf: 1'b0, ovf: 1'b0};

endpackage

// File: rtl/wmbp_level_cmp.sv
module wmbp_level_cmp #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] distance,
  input  logic [AW-1:0] hi_mark,
  input  logic [AW-1:0] lo_mark,
  output logic          ovf,
  output logic          unf,
  output logic          empty
);

  // Strict comparisons on both watermarks.
  always_comb begin
    ovf   = (distance > hi_mark);
    unf   = (distance < lo_mark);
    empty = (distance == '0);
  end

endmodule

// File: rtl/wmbp_bp_track.sv
module wmbp_bp_track #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] rd_ptr,
  input  logic [AW-1:0] wr_ptr,
  input  logic [AW-1:0] bp_addr,
  input  logic          empty,
  input  logic          bp_arm,
  output logic          bp_hit,
  output logic          rd_idle
);

  logic at_bp;
  logic caught_up;

  always_comb begin
    at_bp     = (rd_ptr == bp_addr);
    caught_up = (rd_ptr == wr_ptr);
    // flag only reports a parked reader while the comparator is armed
    bp_hit    = bp_arm & at_bp;
    // the reader is idle whenever it has nothing it may fetch
    rd_idle   = empty | caught_up | at_bp;
  end

endmodule

// File: rtl/wmbp_ctrl_regs.sv
module wmbp_ctrl_regs
  import wmbp_pkg::*;
#(
  parameter int              REG_AW     = 4,
  parameter logic [REG_AW-1:0] STATUS_OFS = 'h0,
  parameter logic [REG_AW-1:0] CTRL_OFS   = 'h2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [REG_W-1:0]  reg_wdata,
  input  stat_t             stat,
  output ctrl_t             ctrl,
  output logic [REG_W-1:0]  reg_rdata
);

  ctrl_t ctrl_q;
  ctrl_t ctrl_d;
  logic  ctrl_we;

  // next state
  always_comb begin
    ctrl_we = reg_wr_en & (reg_addr == CTRL_OFS);
    ctrl_d  = ctrl_t'(reg_wdata[CTRL_W-1:0]);
  end

  // register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl = ctrl_q;

  // read mux, upper bits zero
  always_comb begin
    unique case (reg_addr)
      STATUS_OFS: reg_rdata = REG_W'(stat);
      CTRL_OFS:   reg_rdata = REG_W'(ctrl_q);
      default:    reg_rdata = '0;
    endcase
  end

  AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr != CTRL_OFS) |=> $stable(ctrl_q)); // R9

endmodule

// File: rtl/wmbp_irq_ctrl.sv
module wmbp_irq_ctrl
  import wmbp_pkg::*;
#(
  parameter int AW     = 32,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     distance,
  input  logic [AW-1:0]     rd_ptr,
  input  logic [AW-1:0]     wr_ptr,
  input  logic [AW-1:0]     bp_addr,
  input  logic [AW-1:0]     hi_mark,
  input  logic [AW-1:0]     lo_mark,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              rd_en,
  output logic              link_en,
  output logic              irq
);

  localparam int SYNC_STAGES = 2;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_pipe[SYNC_STAGES-1];

  // flag generation
  logic  ovf_c, unf_c, empty_c, bp_c, ridle_c;
  ctrl_t ctrl;
  stat_t stat_d, stat_q;
  logic  irq_d, irq_q;

  wmbp_level_cmp #(.AW(AW)) u_level (
    .distance (distance),
    .hi_mark  (hi_mark),
    .lo_mark  (lo_mark),
    .ovf      (ovf_c),
    .unf      (unf_c),
    .empty    (empty_c)
  );

  wmbp_bp_track #(.AW(AW)) u_bp (
    .rd_ptr  (rd_ptr),
    .wr_ptr  (wr_ptr),
    .bp_addr (bp_addr),
    .empty   (empty_c),
    .bp_arm  (ctrl.bp_arm),
    .bp_hit  (bp_c),
    .rd_idle (ridle_c)
  );

  wmbp_ctrl_regs #(.REG_AW(REG_AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .reg_addr  (reg_addr),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .stat      (stat_q),
    .ctrl      (ctrl),
    .reg_rdata (reg_rdata)
  );

  // next state
  always_comb begin
    stat_d.ovf      = ovf_c;
    stat_d.unf      = unf_c;
    stat_d.rd_idle  = ridle_c;
    stat_d.cmd_idle = empty_c;
    stat_d.bp       = bp_c;
    irq_d = ctrl.rd_en & ((bp_c  & ctrl.bp_ie)  |
                          (ovf_c & ctrl.ovf_ie) |
                          (unf_c & ctrl.unf_ie));
  end

  // state registers, updated every cycle
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      stat_q <= STAT_RESET;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= irq_d;
    end
  end

  assign irq     = irq_q;
  assign rd_en   = ctrl.rd_en;
  assign link_en = ctrl.link;

  AST_IRQ_NEEDS_READ_EN: assert property (@(posedge clk) disable iff (!rst_n_int)
    irq_q |-> $past(ctrl.rd_en)); // R6
  AST_BP_HELD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n_int)
    !ctrl.bp_arm |=> !stat_q.bp); // R3
  AST_CMD_IDLE_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n_int)
    stat_q.cmd_idle |-> stat_q.rd_idle); // R5
  AST_OVF_STRICT: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(stat_q.ovf) |-> $past(distance > hi_mark)); // R1
  AST_UNF_STRICT: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(stat_q.unf) |-> $past(distance < lo_mark)); // R2

endmodule

// File: tb/wmbp_irq_ctrl_bench.sv
module wmbp_irq_ctrl_bench;

  localparam int AW = 32;
  localparam int RA = 4;
  localparam logic [RA-1:0] A_STAT = 4'h0;
  localparam logic [RA-1:0] A_CTRL = 4'h2;
  localparam logic [AW-1:0] HI = 32'h400;
  localparam logic [AW-1:0] LO = 32'h10;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] distance, rd_ptr, wr_ptr, bp_addr, hi_mark, lo_mark;
  logic [RA-1:0] reg_addr;
  logic          reg_wr_en;
  logic [15:0]   reg_wdata, reg_rdata;
  logic          rd_en, link_en, irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  wmbp_irq_ctrl #(.AW(AW), .REG_AW(RA)) u_wmbp_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .distance(distance), .rd_ptr(rd_ptr),
    .wr_ptr(wr_ptr), .bp_addr(bp_addr), .hi_mark(hi_mark), .lo_mark(lo_mark),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rd_en(rd_en), .link_en(link_en), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [RA-1:0] a, output logic [15:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wr(input logic [RA-1:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic quiet();
    distance = 32'h40; rd_ptr = 32'h100; wr_ptr = 32'h200; bp_addr = 32'h300;
    hi_mark = HI; lo_mark = LO;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_wdata = '0; reg_addr = A_STAT;
    quiet();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(A_STAT, v); check("R8 status at reset", v, 16'h000C);
    rd(A_CTRL, v); check("R8 ctrl at reset", v, 16'h0000);
    check("R8 irq at reset", {15'd0, irq}, 16'h0000);
    repeat (3) step();
    rd(A_STAT, v); check("R8 quiet status", v, 16'h0000);
  endtask

  task automatic t_marks();
    logic [15:0] v;
    quiet(); distance = HI + 1; step();
    rd(A_STAT, v); check("R1 above high", v, 16'h0001);
    distance = HI; step();
    rd(A_STAT, v); check("R1 equal high", v, 16'h0000);
    distance = LO - 1; step();
    rd(A_STAT, v); check("R2 below low", v, 16'h0002);
    distance = LO; step();
    rd(A_STAT, v); check("R2 equal low", v, 16'h0000);
  endtask

  task automatic t_idle();
    logic [15:0] v;
    quiet(); distance = 0; step();
    rd(A_STAT, v); check("R4 empty", v, 16'h000E);
    quiet(); rd_ptr = wr_ptr; step();
    rd(A_STAT, v); check("R5 caught up", v, 16'h0004);
    quiet(); rd_ptr = bp_addr; step();
    rd(A_STAT, v); check("R5 parked on bp, R3 unarmed", v, 16'h0004);
  endtask

  task automatic t_bp();
    logic [15:0] v;
    quiet(); wr(A_CTRL, 16'h0002);
    rd_ptr = bp_addr; step();
    rd(A_STAT, v); check("R3 armed hit", v, 16'h0014);
    rd_ptr = bp_addr + 32; step();
    rd(A_STAT, v); check("R3 moved off", v, 16'h0000);
    wr(A_CTRL, 16'h0000);
  endtask

  task automatic t_irq();
    quiet(); distance = HI + 1;
    wr(A_CTRL, 16'h0005);
    check("R7 irq not yet after write", {15'd0, irq}, 16'h0000);
    step(); check("R6 ovf irq", {15'd0, irq}, 16'h0001);
    distance = 32'h40; step();
    check("R7 irq drops one edge later", {15'd0, irq}, 16'h0000);
    distance = HI + 1; wr(A_CTRL, 16'h0004); step();
    check("R6 read enable gates irq", {15'd0, irq}, 16'h0000);
    quiet(); rd_ptr = bp_addr; wr(A_CTRL, 16'h0023); step();
    check("R6 bp irq", {15'd0, irq}, 16'h0001);
    wr(A_CTRL, 16'h0003); step();
    check("R6 bp irq disabled", {15'd0, irq}, 16'h0000);
    quiet(); distance = LO - 1; wr(A_CTRL, 16'h0009); step();
    check("R6 unf irq", {15'd0, irq}, 16'h0001);
    wr(A_CTRL, 16'h0001); step();
    check("R6 unf irq disabled", {15'd0, irq}, 16'h0000);
    wr(A_CTRL, 16'h0000); quiet(); step();
  endtask

  task automatic t_regs();
    logic [15:0] v;
    wr(A_CTRL, 16'h0012);
    wr(A_STAT, 16'hFFFF);
    rd(A_CTRL, v); check("R9 status write ignored", v, 16'h0012);
    wr(4'h6, 16'hFFFF);
    rd(A_CTRL, v); check("R9 unmapped write ignored", v, 16'h0012);
    rd(4'h6, v); check("R9 unmapped reads zero", v, 16'h0000);
    wr(A_CTRL, 16'hFFFF);
    rd(A_CTRL, v); check("R9 ctrl masked", v, 16'h003F);
    check("R9 rd_en/link_en", {14'd0, link_en, rd_en}, 16'h0003);
    wr(A_CTRL, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog expired: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_marks();
    t_idle();
    t_bp();
    t_irq();
    t_regs();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule